// File: doc/BRIEF.md
# Dual-Port Digital I/O Controller with Pattern Interrupts

This block is a small register-mapped digital I/O controller with two ports. Port 0 is eight lines wide, and each line has its own direction bit. Port 1 is four lines wide, and one direction bit sets all four lines together. Every line connects to a pad as a separate output value, output enable and input value. Software reads and writes four byte-wide registers through a simple synchronous bus that has an address, a write strobe, write data and combinational read data.

Port 0 can also raise a single interrupt. The interrupt has three sources:
- **Change detection:** any monitored line changes.
- **Masked pattern match:** the monitored lines equal a programmed value.
- **Strobe:** a rising edge on a separate strobe pin latches Port 0.

A mask selects which Port 0 lines take part in every mode. One multi-function register is steered by the control register. Through it, software reaches the Port 0 directions, the mask, the match value, or the read-only strobe latch. All pin inputs pass through two-flop synchronisers before the block uses them.

The interrupt engine is a four-state machine:
- **States:** `IS_OFF` (interrupt disabled or mode off), `IS_ARMED` (waiting for a trigger), `IS_PENDING` (interrupt asserted and held) and `IS_REARM` (match mode waiting for the pattern to go away).
- **Control write:** any control write leaves the current state. It goes to `IS_OFF` when the enable bit is clear or the mode is off, to `IS_REARM` for match mode, and to `IS_ARMED` otherwise.
- **Other transitions:** `IS_ARMED` goes to `IS_PENDING` on the trigger of the active mode. `IS_REARM` goes to `IS_ARMED` once the masked input differs from the match value. `IS_PENDING` and `IS_OFF` hold until the next control write.

Top module: `dual_port_dio`

## Requirements
- R1: After reset every register reads zero, all output enables are low and the interrupt output is low.
- R2: Offset 0 is Port 0 data. A write stores all 8 bits as output values. A read returns the stored value for bits whose direction is 1 (output) and the synchronised pin value for bits whose direction is 0 (input). The output enable of each Port 0 pin equals its direction bit.
- R3: Offset 1 is Port 1 data. Only bits 3:0 exist, and bits 7:4 always read zero. When control bit 2 is 1, all four Port 1 pins are enabled as outputs and a read returns the stored value. When control bit 2 is 0, a read returns the synchronised pins.
- R4: Offset 2 is the multi-function register, selected by control bits [1:0]:
  - 0 selects the Port 0 directions.
  - 1 selects the mask.
  - 2 selects the match value.
  - 3 selects the strobe latch, which is read-only, so writes to it have no effect.
- R5: Offset 3 is the control register and reads back the value last written. Bits [4:3] set the interrupt mode: 0 off, 1 change, 2 match, 3 strobe. Bit 5 enables the interrupt.
- R6: In change mode, the interrupt rises when any masked Port 0 input changes.
- R7: In match mode, the interrupt rises when the masked Port 0 inputs equal the masked match value. After a control write it does not fire again until the masked inputs have stopped matching.
- R8: In strobe mode, a rising edge on the strobe pin stores the masked Port 0 inputs in the strobe latch and raises the interrupt.
- R9: Port 0 lines whose mask bit is 0 take part in neither change detection nor the match comparison, and they are stored as 0 in the strobe latch.
- R10: The interrupt stays high until the next write to the control register, which drops it at once. It never rises while control bit 5 is 0.
- R11: A change on a Port 0 pin shows up in a Port 0 read after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| p0_pin_i | input | 8 | Port 0 pad input values |
| p0_pin_o | output | 8 | Port 0 pad output values |
| p0_pin_oe | output | 8 | Port 0 per-line output enables |
| p1_pin_i | input | 4 | Port 1 pad input values |
| p1_pin_o | output | 4 | Port 1 pad output values |
| p1_pin_oe | output | 4 | Port 1 output enables (all equal) |
| strobe_i | input | 1 | Strobe pin, asynchronous |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that the bus inputs are steady around each rising clock edge and that control bits [1:0] do not change in the cycle in which the multi-function register is written. The bench drives every bus signal and every pin on the falling edge and changes the control register only through separate, completed write cycles. The pins may change at any time, since the synchronisers absorb them. The bench keeps its pin changes at least three edges apart whenever it expects a trigger, so that each change is seen on its own.

// File: rtl/dio_pkg.sv
package dio_pkg;

    typedef enum logic [1:0] {
        IM_OFF    = 2'd0,
        IM_EVENT  = 2'd1,
        IM_MATCH  = 2'd2,
        IM_STROBE = 2'd3
    } irq_mode_e;

    typedef enum logic [1:0] {
        MF_DIR   = 2'd0,
        MF_MASK  = 2'd1,
        MF_MATCH = 2'd2,
        MF_LATCH = 2'd3
    } mf_sel_e;

    typedef enum logic [1:0] {
        IS_OFF     = 2'd0,
        IS_ARMED   = 2'd1,
        IS_PENDING = 2'd2,
        IS_REARM   = 2'd3
    } irq_state_e;

    localparam int ADDR_W       = 2;
    localparam logic [1:0] OFS_P0   = 2'd0;
    localparam logic [1:0] OFS_P1   = 2'd1;
    localparam logic [1:0] OFS_MF   = 2'd2;
    localparam logic [1:0] OFS_CTL  = 2'd3;

    localparam int CTL_SEL_LO   = 0;
    localparam int CTL_P1DIR    = 2;
    localparam int CTL_MODE_LO  = 3;
    localparam int CTL_IE       = 5;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/dio_regs.sv
module dio_regs
    import dio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int P1W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [DW-1:0]     p0_sync_i,
    input  logic [P1W-1:0]    p1_sync_i,
    input  logic [DW-1:0]     latch_i,
    output logic [DW-1:0]     p0_dir_o,
    output logic [DW-1:0]     p0_out_o,
    output logic              p1_dir_o,
    output logic [P1W-1:0]    p1_out_o,
    output logic [DW-1:0]     mask_o,
    output logic [DW-1:0]     match_o,
    output mf_sel_e           mf_sel_o,
    output irq_mode_e         mode_o,
    output logic              ie_o,
    output logic              ctl_wr_o,
    output irq_mode_e         new_mode_o,
    output logic              new_ie_o
);
    localparam int RSV_W = DW - P1W;

    logic [DW-1:0]  p0_dir_q;
    logic [DW-1:0]  p0_out_q;
    logic [P1W-1:0] p1_out_q;
    logic [DW-1:0]  mask_q;
    logic [DW-1:0]  match_q;
    logic [DW-1:0]  ctl_q;

    logic wr_p0, wr_p1, wr_mf;
    logic [DW-1:0]  p0_view;
    logic [P1W-1:0] p1_view;
    logic [DW-1:0]  mf_view;

    assign wr_p0    = we_i && (addr_i == OFS_P0);
    assign wr_p1    = we_i && (addr_i == OFS_P1);
    assign wr_mf    = we_i && (addr_i == OFS_MF);
    assign ctl_wr_o = we_i && (addr_i == OFS_CTL);

    assign mf_sel_o   = mf_sel_e'(ctl_q[CTL_SEL_LO +: 2]);
    assign mode_o     = irq_mode_e'(ctl_q[CTL_MODE_LO +: 2]);
    assign ie_o       = ctl_q[CTL_IE];
    assign p1_dir_o   = ctl_q[CTL_P1DIR];
    assign new_mode_o = irq_mode_e'(wdata_i[CTL_MODE_LO +: 2]);
    assign new_ie_o   = wdata_i[CTL_IE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0_out_q <= '0;
            p1_out_q <= '0;
            ctl_q    <= '0;
        end else begin
            if (wr_p0)    p0_out_q <= wdata_i;
            if (wr_p1)    p1_out_q <= wdata_i[P1W-1:0];
            if (ctl_wr_o) ctl_q    <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0_dir_q <= '0;
            mask_q   <= '0;
            match_q  <= '0;
        end else if (wr_mf) begin
            unique case (mf_sel_o)
                MF_DIR:   p0_dir_q <= wdata_i;
                MF_MASK:  mask_q   <= wdata_i;
                MF_MATCH: match_q  <= wdata_i;
                MF_LATCH: ;
            endcase
        end
    end

    assign p0_view = (p0_dir_q & p0_out_q) | (~p0_dir_q & p0_sync_i);
    assign p1_view = p1_dir_o ? p1_out_q : p1_sync_i;

    always_comb begin
        unique case (mf_sel_o)
            MF_DIR:   mf_view = p0_dir_q;
            MF_MASK:  mf_view = mask_q;
            MF_MATCH: mf_view = match_q;
            MF_LATCH: mf_view = latch_i;
        endcase
    end

    always_comb begin
        unique case (addr_i)
            OFS_P0:  rdata_o = p0_view;
            OFS_P1:  rdata_o = {{RSV_W{1'b0}}, p1_view};
            OFS_MF:  rdata_o = mf_view;
            default: rdata_o = ctl_q;
        endcase
    end

    assign p0_dir_o = p0_dir_q;
    assign p0_out_o = p0_out_q;
    assign p1_out_o = p1_out_q;
    assign mask_o   = mask_q;
    assign match_o  = match_q;
endmodule

// File: rtl/dio_irq_fsm.sv
module dio_irq_fsm
    import dio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr_i,
    input  irq_mode_e     new_mode_i,
    input  logic          new_ie_i,
    input  irq_mode_e     mode_i,
    input  logic [DW-1:0] p0_sync_i,
    input  logic          stb_sync_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] match_i,
    output logic          irq_o,
    output logic [DW-1:0] latch_o
);
    irq_state_e    state_q, state_d;
    logic [DW-1:0] p0_prev_q;
    logic          stb_prev_q;
    logic [DW-1:0] latch_q;

    logic chg_hit, match_hit, stb_rise, trig;

    assign chg_hit   = |((p0_sync_i ^ p0_prev_q) & mask_i);
    assign match_hit = ~|((p0_sync_i ^ match_i) & mask_i);
    assign stb_rise  = stb_sync_i & ~stb_prev_q;

    always_comb begin
        trig = 1'b0;
        unique case (mode_i)
            IM_EVENT:  trig = chg_hit;
            IM_MATCH:  trig = match_hit;
            IM_STROBE: trig = stb_rise;
            IM_OFF:    trig = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IS_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctl_wr_i) begin
            if (!new_ie_i || new_mode_i == IM_OFF) state_d = IS_OFF;
            else if (new_mode_i == IM_MATCH)       state_d = IS_REARM;
            else                                   state_d = IS_ARMED;
        end else begin
            unique case (state_q)
                IS_OFF:     state_d = IS_OFF;
                IS_ARMED:   if (trig) state_d = IS_PENDING;
                IS_PENDING: state_d = IS_PENDING;
                IS_REARM:   if (!match_hit) state_d = IS_ARMED;
            endcase
        end
    end

    // outputs
    always_comb begin
        irq_o = (state_q == IS_PENDING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0_prev_q  <= '0;
            stb_prev_q <= 1'b0;
            latch_q    <= '0;
        end else begin
            p0_prev_q  <= p0_sync_i;
            stb_prev_q <= stb_sync_i;
            if (mode_i == IM_STROBE && stb_rise) latch_q <= p0_sync_i & mask_i;
        end
    end

    assign latch_o = latch_q;
endmodule

// File: rtl/dual_port_dio.sv
module dual_port_dio
    import dio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int P1W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     p0_pin_i,
    output logic [DW-1:0]     p0_pin_o,
    output logic [DW-1:0]     p0_pin_oe,
    input  logic [P1W-1:0]    p1_pin_i,
    output logic [P1W-1:0]    p1_pin_o,
    output logic [P1W-1:0]    p1_pin_oe,
    input  logic              strobe_i,
    output logic              irq_o
);
    localparam int SYNC_W = DW + P1W + 1;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [DW-1:0]     p0_sync;
    logic [P1W-1:0]    p1_sync;
    logic              stb_sync;

    logic [DW-1:0]  p0_dir, p0_out, mask, match, latch_val;
    logic           p1_dir, ctl_wr, ctl_ie, new_ie;
    logic [P1W-1:0] p1_out;
    mf_sel_e        mf_sel;
    irq_mode_e      irq_mode, new_mode;

    assign sync_in = {strobe_i, p1_pin_i, p0_pin_i};

    dio_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign p0_sync  = sync_out[DW-1:0];
    assign p1_sync  = sync_out[DW +: P1W];
    assign stb_sync = sync_out[SYNC_W-1];

    dio_regs #(.DW(DW), .P1W(P1W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .p0_sync_i  (p0_sync),
        .p1_sync_i  (p1_sync),
        .latch_i    (latch_val),
        .p0_dir_o   (p0_dir),
        .p0_out_o   (p0_out),
        .p1_dir_o   (p1_dir),
        .p1_out_o   (p1_out),
        .mask_o     (mask),
        .match_o    (match),
        .mf_sel_o   (mf_sel),
        .mode_o     (irq_mode),
        .ie_o       (ctl_ie),
        .ctl_wr_o   (ctl_wr),
        .new_mode_o (new_mode),
        .new_ie_o   (new_ie)
    );

    dio_irq_fsm #(.DW(DW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr),
        .new_mode_i (new_mode),
        .new_ie_i   (new_ie),
        .mode_i     (irq_mode),
        .p0_sync_i  (p0_sync),
        .stb_sync_i (stb_sync),
        .mask_i     (mask),
        .match_i    (match),
        .irq_o      (irq_o),
        .latch_o    (latch_val)
    );

    assign p0_pin_o  = p0_out;
    assign p0_pin_oe = p0_dir;
    assign p1_pin_o  = p1_out;
    assign p1_pin_oe = {P1W{p1_dir}};
endmodule

// File: rtl/dual_port_dio_checks.sv
module dual_port_dio_checks
    import dio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int P1W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [DW-1:0]     p0_pin_oe,
    input logic [P1W-1:0]    p1_pin_oe,
    input logic              irq_o,
    input mf_sel_e           mf_sel,
    input irq_mode_e         irq_mode,
    input logic              ctl_ie
);
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_we && bus_addr == OFS_CTL)) |=> irq_o);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTL) |=> !irq_o);

    p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_ie && irq_mode != IM_OFF));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MF && mf_sel == MF_DIR) |=> (p0_pin_oe == $past(bus_wdata)));

    p_p1_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_P1) |-> (bus_rdata[DW-1:P1W] == '0));

    p_p1_oe_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(p1_pin_oe) == 0) || ($countones(p1_pin_oe) == P1W));
endmodule

bind dual_port_dio dual_port_dio_checks #(.DW(DW), .P1W(P1W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .p0_pin_oe (p0_pin_oe),
    .p1_pin_oe (p1_pin_oe),
    .irq_o     (irq_o),
    .mf_sel    (mf_sel),
    .irq_mode  (irq_mode),
    .ctl_ie    (ctl_ie)
);

// File: tb/dual_port_dio_test.sv
`timescale 1ns/1ps
module dual_port_dio_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] p0_pin_i = '0;
    logic [7:0] p0_pin_o, p0_pin_oe;
    logic [3:0] p1_pin_i = '0;
    logic [3:0] p1_pin_o, p1_pin_oe;
    logic       strobe_i = 1'b0;
    logic       irq_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    dual_port_dio uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .p0_pin_i(p0_pin_i), .p0_pin_o(p0_pin_o), .p0_pin_oe(p0_pin_oe),
        .p1_pin_i(p1_pin_i), .p1_pin_o(p1_pin_o), .p1_pin_oe(p1_pin_oe),
        .strobe_i(strobe_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_p0(logic [7:0] d, logic [7:0] o, logic [7:0] p);
        return (d & o) | (~d & p);
    endfunction

    function automatic logic [7:0] exp_p1(logic b, logic [7:0] o, logic [3:0] p);
        return b ? {4'h0, o[3:0]} : {4'h0, p};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk("R1 p0_oe", p0_pin_oe, 8'h00);
        chk("R1 p1_oe", {4'h0, p1_pin_oe}, 8'h00);
        chk("R1 irq", {7'h0, irq_o}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv);
            chk("R1 reg read", rv, 8'h00);
        end

        // R11: two-edge synchroniser latency on a Port 0 read
        @(negedge clk);
        bus_addr = 2'd0;
        p0_pin_i = 8'h5A;
        @(negedge clk);
        #1 chk("R11 one edge old", bus_rdata, 8'h00);
        @(negedge clk);
        #1 chk("R11 two edges new", bus_rdata, 8'h5A);

        // R5: control read-back
        wr(2'd3, 8'h2D);
        rd(2'd3, rv);
        chk("R5 ctl readback", rv, 8'h2D);
        wr(2'd3, 8'h00);

        // R6 / R9: change mode with mask 0x0F
        p0_pin_i = 8'h00;
        wr(2'd3, 8'h01);
        wr(2'd2, 8'h0F);
        rd(2'd2, rv);
        chk("R4 mask view", rv, 8'h0F);
        idle(3);
        wr(2'd3, 8'h29);
        idle(4);
        chk("R6 quiet no irq", {7'h0, irq_o}, 8'h00);
        p0_pin_i = 8'h80;
        idle(6);
        chk("R9 masked change ignored", {7'h0, irq_o}, 8'h00);
        p0_pin_i = 8'h81;
        idle(4);
        chk("R6 change irq", {7'h0, irq_o}, 8'h01);
        idle(5);
        chk("R10 sticky", {7'h0, irq_o}, 8'h01);
        wr(2'd3, 8'h29);
        chk("R10 cleared by ctl write", {7'h0, irq_o}, 8'h00);

        // R7: match mode, value 0xA5 under mask 0x0F
        wr(2'd3, 8'h02);
        wr(2'd2, 8'hA5);
        rd(2'd2, rv);
        chk("R4 match view", rv, 8'hA5);
        p0_pin_i = 8'h00;
        idle(3);
        wr(2'd3, 8'h32);
        idle(4);
        chk("R7 no match no irq", {7'h0, irq_o}, 8'h00);
        p0_pin_i = 8'hF5;
        idle(4);
        chk("R7 R9 masked match irq", {7'h0, irq_o}, 8'h01);
        wr(2'd3, 8'h32);
        idle(6);
        chk("R7 held pattern no retrigger", {7'h0, irq_o}, 8'h00);
        p0_pin_i = 8'h00;
        idle(4);
        p0_pin_i = 8'h05;
        idle(4);
        chk("R7 rearmed irq", {7'h0, irq_o}, 8'h01);

        // R10: enable bit clear suppresses
        p0_pin_i = 8'h00;
        wr(2'd3, 8'h12);
        idle(4);
        p0_pin_i = 8'h05;
        idle(6);
        chk("R10 disabled no irq", {7'h0, irq_o}, 8'h00);

        // R8: strobe mode, mask 0xFF
        wr(2'd3, 8'h01);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h3B);
        p0_pin_i = 8'h3C;
        strobe_i = 1'b1;
        idle(4);
        chk("R8 strobe irq", {7'h0, irq_o}, 8'h01);
        rd(2'd2, rv);
        chk("R8 latch value", rv, 8'h3C);
        p0_pin_i = 8'h11;
        idle(4);
        rd(2'd2, rv);
        chk("R8 latch holds", rv, 8'h3C);

        // R9: strobe latch masked
        strobe_i = 1'b0;
        wr(2'd3, 8'h01);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h3B);
        idle(3);
        p0_pin_i = 8'hC7;
        strobe_i = 1'b1;
        idle(4);
        rd(2'd2, rv);
        chk("R9 masked latch", rv, 8'h07);
        // R4: latch view is read-only
        wr(2'd2, 8'hFF);
        rd(2'd2, rv);
        chk("R4 latch write ignored", rv, 8'h07);
        strobe_i = 1'b0;
        wr(2'd3, 8'h00);

        // R2 / R3: random directions, values and pins
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d, o, p, o1;
            logic [3:0] p1;
            logic b;
            d = 8'($urandom); o = 8'($urandom); p = 8'($urandom);
            o1 = 8'($urandom); p1 = 4'($urandom); b = 1'($urandom);
            if (i == 0) d = 8'h00;
            if (i == 1) d = 8'hFF;
            wr(2'd3, 8'h00);
            wr(2'd2, d);
            wr(2'd0, o);
            p0_pin_i = p;
            wr(2'd3, {5'b0, b, 2'b00});
            wr(2'd1, o1);
            p1_pin_i = p1;
            idle(3);
            chk("R2 p0_oe", p0_pin_oe, d);
            chk("R2 p0_out", p0_pin_o, o);
            rd(2'd0, rv);
            chk("R2 p0 read", rv, exp_p0(d, o, p));
            rd(2'd1, rv);
            chk("R3 p1 read", rv, exp_p1(b, o1, p1));
            chk("R3 p1_oe", {4'h0, p1_pin_oe}, {4'h0, {4{b}}});
        end

        finish_run();
    end
endmodule